// File: doc/BRIEF.md
# Exception Entry/Exit Sequencer

This block drives the architectural state changes a 32-bit core makes when it takes an exception and when a handler returns. Each cycle it looks at the pending exception requests, the current program counter, the current status word and a return command. It then issues, one cycle later, write strobes and values for the banked return-address register, the banked saved-status register, the new status word and the new program counter. These updates are applied by the register file and fetch logic around it.

On entry the block picks one request by fixed priority. It saves a return address whose offset depends on both the exception kind and the instruction-width state the core was in. It copies the status word into the bank of the target mode, forces the mode field, clears the narrow-instruction bit, raises the interrupt masks, and jumps to the exception's vector. The block keeps its own copy of each bank's saved address, saved status and entry kind. On a return command it reloads the program counter from the saved address minus a kind-specific offset and restores the saved status word. That restore also brings back the instruction-width state and the masks as they were before entry.

Top module: `exc_seq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises with no request, all four write strobes (lr_we, spsr_we, psr_we, pc_we) are 0, even if requests are asserted during reset.
- R2: Request bit positions in exc_req are 0 reset, 1 undefined instruction, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ. The winner is picked in the order reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt. IRQ is ignored when cur_psr[7] is 1 and FIQ is ignored when cur_psr[6] is 1. Reset is never ignored.
- R3: On entry, psr_we is 1 one cycle after the request. psr_data equals cur_psr with the following changes: bits [4:0] hold the mode (10011 for reset and software interrupt, 11011 for undefined, 10111 for both aborts, 10010 for IRQ, 10001 for FIQ), bit 5 (narrow-instruction state) is 0, and bit 7 (IRQ mask) is 1. Bit 6 (FIQ mask) is set to 1 for reset and FIQ and is otherwise unchanged.
- R4: On entry, pc_we is 1 and pc_data is the vector: 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ, 0x1C FIQ.
- R5: On entry other than reset, lr_we is 1 and lr_data is cur_pc plus 8 for data abort. It is cur_pc plus 2 for undefined or software interrupt when cur_psr[5] is 1, and cur_pc plus 4 in all other cases.
- R6: On entry other than reset, spsr_we is 1 and spsr_data is cur_psr. lr_bank and spsr_bank both hold the bank index: 0 supervisor, 1 undefined, 2 abort, 3 IRQ, 4 FIQ. A reset entry writes neither bank register.
- R7: When ret_go is 1 and no request wins, and cur_psr[4:0] names a banked mode, the exit takes effect one cycle later. pc_we is 1 and pc_data is that bank's saved address minus 0 (undefined or software interrupt), minus 8 (data abort) or minus 4 (other kinds), using the kind of the latest entry into that bank. psr_we is 1 and psr_data is the bank's saved status. Banks reset to address 0, status 0 and offset 0.
- R8: ret_go has no effect when cur_psr[4:0] is 10000 or 11111, or when an exception request wins in the same cycle.
- R9: A cycle with no winning request and no accepted return produces no write strobe in the next cycle, and an exit never writes lr or spsr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 7 | Exception request lines, bit positions per R2 |
| ret_go | input | 1 | Handler return command |
| cur_pc | input | 32 | Current program counter |
| cur_psr | input | 32 | Current status word |
| lr_we | output | 1 | Banked return-address write strobe |
| lr_bank | output | 3 | Bank index for the return-address write |
| lr_data | output | 32 | Return address to write |
| spsr_we | output | 1 | Banked saved-status write strobe |
| spsr_bank | output | 3 | Bank index for the saved-status write |
| spsr_data | output | 32 | Status word to save |
| psr_we | output | 1 | Current status write strobe |
| psr_data | output | 32 | New current status word |
| pc_we | output | 1 | Program counter write strobe |
| pc_data | output | 32 | New program counter |

## Verification
The directed cases first take a software interrupt from the narrow-instruction state and a data abort from the wide state. Each is returned from, which separates the state-dependent link offset from the kind-dependent return offset. All seven requests are then raised together, IRQ and FIQ are raised with only one mask set, and a lone masked IRQ is raised. These cases separate the priority order from the masking. Return commands are issued in user and system modes and together with a request, which shows when a return must be dropped. A seeded random phase then feeds the block's own status output back as the core's status and mixes random requests, masks, modes and returns. This produces nested entries and exits that exercise the per-bank saved kind.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int NUM_REQ   = 7;
   localparam int NUM_BANKS = 5;
   localparam int BANK_W    = $clog2(NUM_BANKS);

   typedef enum logic [2:0] {
      K_RST  = 3'd0,
      K_UND  = 3'd1,
      K_SWI  = 3'd2,
      K_PABT = 3'd3,
      K_DABT = 3'd4,
      K_IRQ  = 3'd5,
      K_FIQ  = 3'd6,
      K_NONE = 3'd7
   } exc_kind_e;

   typedef struct packed {
      logic              ok;
      logic [BANK_W-1:0] idx;
   } bank_sel_t;

   localparam logic [4:0] MODE_USR = 5'b10000;
   localparam logic [4:0] MODE_FIQ = 5'b10001;
   localparam logic [4:0] MODE_IRQ = 5'b10010;
   localparam logic [4:0] MODE_SVC = 5'b10011;
   localparam logic [4:0] MODE_ABT = 5'b10111;
   localparam logic [4:0] MODE_UND = 5'b11011;
   localparam logic [4:0] MODE_SYS = 5'b11111;

   localparam int PSR_T = 5;
   localparam int PSR_F = 6;
   localparam int PSR_I = 7;

   function automatic logic [7:0] kind_vector(exc_kind_e k);
      case (k)
         K_UND:   return 8'h04;
         K_SWI:   return 8'h08;
         K_PABT:  return 8'h0C;
         K_DABT:  return 8'h10;
         K_IRQ:   return 8'h18;
         K_FIQ:   return 8'h1C;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [4:0] kind_mode(exc_kind_e k);
      case (k)
         K_UND:          return MODE_UND;
         K_PABT, K_DABT: return MODE_ABT;
         K_IRQ:          return MODE_IRQ;
         K_FIQ:          return MODE_FIQ;
         default:        return MODE_SVC;
      endcase
   endfunction

   function automatic logic [BANK_W-1:0] kind_bank(exc_kind_e k);
      case (k)
         K_UND:          return BANK_W'(1);
         K_PABT, K_DABT: return BANK_W'(2);
         K_IRQ:          return BANK_W'(3);
         K_FIQ:          return BANK_W'(4);
         default:        return BANK_W'(0);
      endcase
   endfunction

   // Link offset: chosen so that one return sequence per kind fits both states.
   function automatic logic [3:0] link_add(exc_kind_e k, logic narrow);
      case (k)
         K_DABT:       return 4'd8;
         K_UND, K_SWI: return narrow ? 4'd2 : 4'd4;
         default:      return 4'd4;
      endcase
   endfunction

   function automatic logic [3:0] ret_sub(exc_kind_e k);
      case (k)
         K_UND, K_SWI: return 4'd0;
         K_DABT:       return 4'd8;
         default:      return 4'd4;
      endcase
   endfunction

   function automatic bank_sel_t mode_to_bank(logic [4:0] m);
      bank_sel_t s;
      s.ok  = 1'b1;
      s.idx = '0;
      case (m)
         MODE_SVC: s.idx = BANK_W'(0);
         MODE_UND: s.idx = BANK_W'(1);
         MODE_ABT: s.idx = BANK_W'(2);
         MODE_IRQ: s.idx = BANK_W'(3);
         MODE_FIQ: s.idx = BANK_W'(4);
         default:  s.ok  = 1'b0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/exc_pick.sv
module exc_pick
   import exc_pkg::*;
#(
   parameter int HONOR_MASKS = 1
) (
   input  logic [NUM_REQ-1:0] req,
   input  logic               irq_off,
   input  logic               fiq_off,
   output exc_kind_e          grant,
   output logic               grant_any
);

   logic [NUM_REQ-1:0] eff;

   generate
      if (HONOR_MASKS != 0) begin : g_mask
         always_comb begin
            eff             = req;
            eff[int'(K_IRQ)] = req[int'(K_IRQ)] & ~irq_off;
            eff[int'(K_FIQ)] = req[int'(K_FIQ)] & ~fiq_off;
         end
      end else begin : g_nomask
         logic unused_masks;
         assign unused_masks = irq_off ^ fiq_off;
         assign eff = req;
      end
   endgenerate

   always_comb begin
      grant = K_NONE;
      if      (eff[int'(K_RST)])  grant = K_RST;
      else if (eff[int'(K_DABT)]) grant = K_DABT;
      else if (eff[int'(K_FIQ)])  grant = K_FIQ;
      else if (eff[int'(K_IRQ)])  grant = K_IRQ;
      else if (eff[int'(K_PABT)]) grant = K_PABT;
      else if (eff[int'(K_UND)])  grant = K_UND;
      else if (eff[int'(K_SWI)])  grant = K_SWI;
      grant_any = (grant != K_NONE);
   end

   // R2: a granted kind was actually requested on its line
   always_comb begin
      if (grant_any) begin
         a_r2_grant_requested: assert (req[grant] == 1'b1)
            else $error("R2: grant without request");
      end
   end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
   import exc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_idx,
   input  logic [XLEN-1:0]   wr_lr,
   input  logic [XLEN-1:0]   wr_psr,
   input  exc_kind_e         wr_kind,
   input  logic [BANK_W-1:0] rd_idx,
   output logic [XLEN-1:0]   rd_lr,
   output logic [XLEN-1:0]   rd_psr,
   output exc_kind_e         rd_kind
);

   logic [XLEN-1:0] lr_q   [NUM_BANKS];
   logic [XLEN-1:0] psr_q  [NUM_BANKS];
   exc_kind_e       kind_q [NUM_BANKS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_BANKS; i++) begin
            lr_q[i]   <= '0;
            psr_q[i]  <= '0;
            kind_q[i] <= K_SWI;
         end
      end else if (wr_en) begin
         lr_q[wr_idx]   <= wr_lr;
         psr_q[wr_idx]  <= wr_psr;
         kind_q[wr_idx] <= wr_kind;
      end
   end

   always_comb begin
      rd_lr   = '0;
      rd_psr  = '0;
      rd_kind = K_SWI;
      if (int'(rd_idx) < NUM_BANKS) begin
         rd_lr   = lr_q[rd_idx];
         rd_psr  = psr_q[rd_idx];
         rd_kind = kind_q[rd_idx];
      end
   end

   // R7: a saved entry is what the bank holds on the following cycle
   a_r7_bank_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (lr_q[$past(wr_idx)] == $past(wr_lr)) &&
                (psr_q[$past(wr_idx)] == $past(wr_psr)))
      else $error("R7: bank write lost");

endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int HONOR_MASKS = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [6:0]          exc_req,
   input  logic                ret_go,
   input  logic [XLEN-1:0]     cur_pc,
   input  logic [XLEN-1:0]     cur_psr,
   output logic                lr_we,
   output logic [2:0]          lr_bank,
   output logic [XLEN-1:0]     lr_data,
   output logic                spsr_we,
   output logic [2:0]          spsr_bank,
   output logic [XLEN-1:0]     spsr_data,
   output logic                psr_we,
   output logic [XLEN-1:0]     psr_data,
   output logic                pc_we,
   output logic [XLEN-1:0]     pc_data
);

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("exc_seq: XLEN must be at least 8");
      end
      if (HONOR_MASKS != 0 && HONOR_MASKS != 1) begin : g_bad_mask
         $error("exc_seq: HONOR_MASKS must be 0 or 1");
      end
      if (BANK_W != 3 || NUM_REQ != 7) begin : g_bad_pkg
         $error("exc_seq: port widths assume 7 requests and 3-bit bank index");
      end
   endgenerate

   exc_kind_e       grant;
   logic            grant_any;
   bank_sel_t       cur_bank;
   logic [XLEN-1:0] rd_lr;
   logic [XLEN-1:0] rd_psr;
   exc_kind_e       rd_kind;
   logic            bank_wr;
   logic            take_exit;
   logic [XLEN-1:0] ent_psr;
   logic [XLEN-1:0] ent_lr;
   logic [XLEN-1:0] ext_pc;

   exc_pick #(.HONOR_MASKS(HONOR_MASKS)) u_pick (
      .req       (exc_req),
      .irq_off   (cur_psr[PSR_I]),
      .fiq_off   (cur_psr[PSR_F]),
      .grant     (grant),
      .grant_any (grant_any)
   );

   always_comb begin
      cur_bank  = mode_to_bank(cur_psr[4:0]);
      bank_wr   = grant_any && (grant != K_RST);
      take_exit = ret_go && !grant_any && cur_bank.ok;

      ent_psr        = cur_psr;
      ent_psr[4:0]   = kind_mode(grant);
      ent_psr[PSR_T] = 1'b0;
      ent_psr[PSR_I] = 1'b1;
      if (grant == K_RST || grant == K_FIQ) ent_psr[PSR_F] = 1'b1;

      ent_lr = cur_pc + XLEN'(link_add(grant, cur_psr[PSR_T]));
      ext_pc = rd_lr - XLEN'(ret_sub(rd_kind));
   end

   exc_bank #(.XLEN(XLEN)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .wr_idx  (kind_bank(grant)),
      .wr_lr   (ent_lr),
      .wr_psr  (cur_psr),
      .wr_kind (grant),
      .rd_idx  (cur_bank.idx),
      .rd_lr   (rd_lr),
      .rd_psr  (rd_psr),
      .rd_kind (rd_kind)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lr_we     <= 1'b0;
         lr_bank   <= '0;
         lr_data   <= '0;
         spsr_we   <= 1'b0;
         spsr_bank <= '0;
         spsr_data <= '0;
         psr_we    <= 1'b0;
         psr_data  <= '0;
         pc_we     <= 1'b0;
         pc_data   <= '0;
      end else begin
         lr_we     <= bank_wr;
         spsr_we   <= bank_wr;
         lr_bank   <= bank_wr ? kind_bank(grant) : '0;
         spsr_bank <= bank_wr ? kind_bank(grant) : '0;
         lr_data   <= bank_wr ? ent_lr : '0;
         spsr_data <= bank_wr ? cur_psr : '0;
         psr_we    <= grant_any || take_exit;
         pc_we     <= grant_any || take_exit;
         if (grant_any) begin
            psr_data <= ent_psr;
            pc_data  <= XLEN'(kind_vector(grant));
         end else if (take_exit) begin
            psr_data <= rd_psr;
            pc_data  <= ext_pc;
         end else begin
            psr_data <= '0;
            pc_data  <= '0;
         end
      end
   end

   // R3: every bank write comes with a wide-state, IRQ-masked status
   a_r3_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |-> psr_we && pc_we && !psr_data[PSR_T] && psr_data[PSR_I])
      else $error("R3: entry status wrong");

   // R4: entry target is a word-aligned low vector
   a_r4_vector: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |-> (pc_data[XLEN-1:5] == '0) && (pc_data[1:0] == 2'b00))
      else $error("R4: vector out of range");

   // R6: saved status and return address go to the same bank together
   a_r6_pair: assert property (@(posedge clk) disable iff (!rst_n)
      spsr_we |-> lr_we && (spsr_bank == lr_bank))
      else $error("R6: bank writes split");

   // R8: a return from an unbanked mode is dropped
   a_r8_unbanked_ret: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_go && (exc_req == '0) &&
       (cur_psr[4:0] == MODE_USR || cur_psr[4:0] == MODE_SYS)) |=> !pc_we)
      else $error("R8: return accepted from unbanked mode");

   // R9: a quiet cycle produces no writes
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((exc_req == '0) && !ret_go) |=> !lr_we && !spsr_we && !psr_we && !pc_we)
      else $error("R9: write without cause");

endmodule

// File: tb/exc_seq_tb.sv
module exc_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  exc_req;
   logic        ret_go;
   logic [31:0] cur_pc;
   logic [31:0] cur_psr;
   logic        lr_we, spsr_we, psr_we, pc_we;
   logic [2:0]  lr_bank, spsr_bank;
   logic [31:0] lr_data, spsr_data, psr_data, pc_data;

   always #10 clk = ~clk;

   exc_seq u_dut (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .ret_go(ret_go),
      .cur_pc(cur_pc), .cur_psr(cur_psr),
      .lr_we(lr_we), .lr_bank(lr_bank), .lr_data(lr_data),
      .spsr_we(spsr_we), .spsr_bank(spsr_bank), .spsr_data(spsr_data),
      .psr_we(psr_we), .psr_data(psr_data), .pc_we(pc_we), .pc_data(pc_data)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // expected outputs
   logic        e_lr_we, e_spsr_we, e_psr_we, e_pc_we, e_entry;
   logic [2:0]  e_bank;
   logic [31:0] e_lr, e_spsr, e_psr, e_pc;
   // bench's own model of saved state per bank
   logic [31:0] m_lr  [5];
   logic [31:0] m_psr [5];
   int          m_kind[5];
   int          prio  [7] = '{0, 4, 6, 5, 3, 1, 2};
   logic [31:0] core_psr;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 5; i++) begin
         m_lr[i] = 0; m_psr[i] = 0; m_kind[i] = 2;
      end
   endtask

   task automatic predict(input logic [6:0] rq, input logic rt,
                          input logic [31:0] pc, input logic [31:0] psr);
      int k;
      k = -1;
      e_lr_we = 0; e_spsr_we = 0; e_psr_we = 0; e_pc_we = 0; e_entry = 0;
      e_bank = 0; e_lr = 0; e_spsr = 0; e_psr = 0; e_pc = 0;
      for (int i = 0; i < 7; i++) begin
         if (k < 0 && rq[prio[i]] && !(prio[i] == 5 && psr[7]) &&
             !(prio[i] == 6 && psr[6]))
            k = prio[i];
      end
      if (k >= 0) begin
         logic [4:0] md;
         int         bk;
         e_entry = 1; e_psr_we = 1; e_pc_we = 1;
         case (k)
            1: begin e_pc = 32'h04; md = 5'b11011; bk = 1; end
            2: begin e_pc = 32'h08; md = 5'b10011; bk = 0; end
            3: begin e_pc = 32'h0C; md = 5'b10111; bk = 2; end
            4: begin e_pc = 32'h10; md = 5'b10111; bk = 2; end
            5: begin e_pc = 32'h18; md = 5'b10010; bk = 3; end
            6: begin e_pc = 32'h1C; md = 5'b10001; bk = 4; end
            default: begin e_pc = 32'h00; md = 5'b10011; bk = 0; end
         endcase
         e_psr = {psr[31:8], 1'b1, ((k == 0 || k == 6) ? 1'b1 : psr[6]), 1'b0, md};
         if (k != 0) begin
            e_lr_we = 1; e_spsr_we = 1; e_bank = 3'(bk); e_spsr = psr;
            if (k == 4)                           e_lr = pc + 8;
            else if (psr[5] && (k == 1 || k == 2)) e_lr = pc + 2;
            else                                  e_lr = pc + 4;
            m_lr[bk] = e_lr; m_psr[bk] = psr; m_kind[bk] = k;
         end
      end else if (rt) begin
         int bk;
         case (psr[4:0])
            5'b10011: bk = 0;
            5'b11011: bk = 1;
            5'b10111: bk = 2;
            5'b10010: bk = 3;
            5'b10001: bk = 4;
            default:  bk = -1;
         endcase
         if (bk >= 0) begin
            e_psr_we = 1; e_pc_we = 1; e_psr = m_psr[bk];
            if (m_kind[bk] == 4)                         e_pc = m_lr[bk] - 8;
            else if (m_kind[bk] == 1 || m_kind[bk] == 2) e_pc = m_lr[bk];
            else                                         e_pc = m_lr[bk] - 4;
         end
      end
   endtask

   task automatic verify();
      string tp, tc;
      tp = e_entry ? "R3" : (e_psr_we ? "R7" : "R9");
      tc = e_entry ? "R4" : (e_pc_we ? "R7" : "R9");
      chk("R5 lr_we", 32'(lr_we), 32'(e_lr_we));
      if (e_lr_we) begin
         chk("R5 lr_data", lr_data, e_lr);
         chk("R6 lr_bank", 32'(lr_bank), 32'(e_bank));
      end
      chk("R6 spsr_we", 32'(spsr_we), 32'(e_spsr_we));
      if (e_spsr_we) begin
         chk("R6 spsr_data", spsr_data, e_spsr);
         chk("R6 spsr_bank", 32'(spsr_bank), 32'(e_bank));
      end
      chk({tp, " psr_we"}, 32'(psr_we), 32'(e_psr_we));
      if (e_psr_we) chk({tp, " psr_data"}, psr_data, e_psr);
      chk({tc, " pc_we"}, 32'(pc_we), 32'(e_pc_we));
      if (e_pc_we) chk({tc, " pc_data"}, pc_data, e_pc);
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic cyc(input logic [6:0] rq, input logic rt,
                      input logic [31:0] pc, input logic [31:0] psr);
      exc_req = rq; ret_go = rt; cur_pc = pc; cur_psr = psr;
      predict(rq, rt, pc, psr);
      @(negedge clk);
      verify();
      if (e_psr_we) core_psr = e_psr;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; exc_req = 7'h7F; ret_go = 1'b1;
      cur_pc = 32'h40; cur_psr = 32'h10;
      model_reset();
      core_psr = 32'h10;
      repeat (3) @(negedge clk);
      // R1: strobes stay low during reset despite requests
      chk("R1 lr_we in reset", 32'(lr_we), 0);
      chk("R1 spsr_we in reset", 32'(spsr_we), 0);
      chk("R1 psr_we in reset", 32'(psr_we), 0);
      chk("R1 pc_we in reset", 32'(pc_we), 0);
      exc_req = 0; ret_go = 0; rst_n = 1'b1;
      @(negedge clk);
      chk("R1 quiet after reset", 32'({lr_we, spsr_we, psr_we, pc_we}), 0);

      // R5: software interrupt from narrow state saves pc+2
      cyc(7'b0000100, 0, 32'h100, 32'h30);
      chk("R5 swi narrow link", lr_data, 32'h102);
      chk("R3 swi status", psr_data, 32'h93);
      // R7: return lands on next narrow instruction, state restored
      cyc(7'b0, 1, 32'h8, 32'h93);
      chk("R7 swi return pc", pc_data, 32'h102);
      chk("R7 swi return status", psr_data, 32'h30);

      // R5/R7: data abort from wide state
      cyc(7'b0010000, 0, 32'h200, 32'h10);
      chk("R5 dabt link", lr_data, 32'h208);
      chk("R4 dabt vector", pc_data, 32'h10);
      cyc(7'b0, 1, 32'h10, 32'h97);
      chk("R7 dabt return pc", pc_data, 32'h200);

      // R2/R6: everything at once -> reset, no bank write
      cyc(7'h7F, 1, 32'h300, 32'h10);
      chk("R2 reset wins vector", pc_data, 32'h0);
      chk("R6 reset no lr", 32'(lr_we), 0);
      chk("R3 reset status", psr_data, 32'hD3);

      // R2: IRQ masked, FIQ open -> FIQ
      cyc(7'b1100000, 0, 32'h400, 32'h90);
      chk("R2 fiq over masked irq", pc_data, 32'h1C);
      chk("R6 fiq bank", 32'(lr_bank), 4);
      // R2: lone IRQ with mask set does nothing
      cyc(7'b0100000, 0, 32'h400, 32'h90);
      chk("R2 masked irq ignored", 32'(pc_we), 0);
      // R8: returns from user and system modes dropped
      cyc(7'b0, 1, 32'h500, 32'h10);
      chk("R8 user return ignored", 32'(psr_we), 0);
      cyc(7'b0, 1, 32'h500, 32'h1F);
      chk("R8 system return ignored", 32'(psr_we), 0);
      // R8: return plus undefined request -> entry taken
      cyc(7'b0000010, 1, 32'h600, 32'h33);
      chk("R8 entry beats return", pc_data, 32'h04);
      chk("R5 undef narrow link", lr_data, 32'h602);
      // R5: prefetch abort from narrow state still pc+4
      cyc(7'b0001000, 0, 32'h700, 32'h30);
      chk("R5 pabt narrow link", lr_data, 32'h704);
      cyc(7'b0, 1, 32'hC, 32'h97);
      chk("R7 pabt return pc", pc_data, 32'h700);

      // random phase with status feedback
      for (int n = 0; n < 4000; n++) begin
         logic [6:0]  rq;
         logic [31:0] psr;
         logic [4:0]  modes [7];
         modes = '{5'b10000, 5'b11111, 5'b10011, 5'b11011, 5'b10111, 5'b10010, 5'b10001};
         rq = 0;
         for (int b = 1; b < 7; b++) if ($urandom_range(9) == 0) rq[b] = 1'b1;
         if ($urandom_range(63) == 0) rq[0] = 1'b1;
         if ($urandom_range(1) == 0) psr = core_psr;
         else begin
            psr = $urandom;
            psr[4:0] = modes[$urandom_range(6)];
         end
         cyc(rq, ($urandom_range(2) == 0), $urandom & 32'hFFFF_FFFE, psr);
      end

      exc_req = 0; ret_go = 0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule